// File: doc/BRIEF.md
# Gated-Clock Duty Cycle Meter

This block measures the duty cycle of a digital waveform over many of its periods. Two counters run from the same system clock. A high-time accumulator steps only in cycles where the synchronized pulse is high, which amounts to the clock ANDed with the pulse. A total-time counter steps on every clock, or on every fourth clock when the block is built for a slow time base. A start strobe clears both counters and enables them in the same cycle. Counting stops on the first of three events: the total counter reaching its end, the high accumulator reaching its end, or a programmed number of rising edges on the input.

Once counting stops, the block reports the raw high count and the total count, both on the system-clock time base. It also reports a fixed-point duty ratio that a restoring divider produces one bit per clock. A typical setting for the edge limit is 100, which gives roughly one percent resolution. The total counter must be wide enough to span at least one full input period.

Top module: `duty_meter`

## Requirements
- R1: The pulse input passes through two synchronizing flops. The high count then equals the number of running cycles in which the second flop holds a one.
- R2: A start strobe accepted while idle does two things at one clock edge. It sets both counts and both flags to zero and sets busy.
- R3: The total count steps once per running cycle. When the slow time-base option is set, it steps once per four running cycles and is reported shifted left by two bits, so its two low bits read 0.
- R4: A rising edge is a cycle where the second synchronizer flop is 1 and the previous value was 0. Counting stops in the running cycle whose rising edge brings the edge tally up to the value of period_limit, provided that value is non-zero. That cycle's increments are included.
- R5: If the high accumulator is all ones and the synchronized pulse is high, counting stops. The high count stays all ones and the overflow flag is set.
- R6: If the total counter is all ones when it would step, counting stops and its raw value stays all ones.
- R7: The invalid flag is set when counting stops through the total counter's end before two rising edges have been seen.
- R8: The duty ratio equals floor(high × 2^RATIO_W / total). It reads all ones whenever the high count is not below the total count.
- R9: The done output is high for exactly one clock once the ratio is valid. Busy falls in that same cycle.
- R10: A start strobe that arrives while busy is high changes neither the measurement nor the flags.
- R11: After reset, busy, done, both counts, the ratio and both flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement (honoured only while idle) |
| pulse_in | input | 1 | Asynchronous waveform under test |
| period_limit | input | PER_W | Rising-edge count that ends the measurement (0 disables) |
| busy | output | 1 | Counting or dividing |
| done | output | 1 | One-cycle completion pulse |
| high_count | output | HIGH_W | High-time count, saturating |
| total_count | output | TOTAL_W or TOTAL_W+2 | Total-time count on the system-clock base |
| duty_ratio | output | RATIO_W | High/total as an unsigned fraction of 2^RATIO_W |
| hovf_flag | output | 1 | High accumulator reached its end |
| invalid_flag | output | 1 | Total counter ended before a full period was seen |

## Verification
The bench builds two copies of the block. The first uses an 8-bit high accumulator, a 10-bit total counter and a full-rate time base. With these widths, accumulator overflow arrives after 256 high cycles and total rollover after about a thousand cycles, so both endings occur within short runs. The second copy has a 12-bit accumulator and the divide-by-four time base. It exercises the shifted total and a rollover that occurs while the wide accumulator still has room. Random period, high time and edge limit combine with directed runs: a constant-low input, a constant-high input, long high phases, a limit of 100, and a start strobe issued during counting.

// File: rtl/dm_pkg.sv
package dm_pkg;
   typedef enum logic [1:0] {
      DM_IDLE = 2'd0,
      DM_RUN  = 2'd1,
      DM_LOAD = 2'd2,
      DM_DIV  = 2'd3
   } dm_state_e;
endpackage

// File: rtl/dm_sync.sv
module dm_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise
);
   logic s1_q, s2_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q   <= 1'b0;
         s2_q   <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         s1_q   <= din;
         s2_q   <= s1_q;
         prev_q <= s2_q;
      end
   end

   assign lvl  = s2_q;
   assign rise = s2_q & ~prev_q;
endmodule

// File: rtl/dm_counters.sv
module dm_counters #(
   parameter int HIGH_W  = 20,
   parameter int TOTAL_W = 16,
   parameter int PER_W   = 8,
   parameter bit DIV4    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               run,
   input  logic               lvl,
   input  logic               rise,
   input  logic [PER_W-1:0]   limit,
   output logic [HIGH_W-1:0]  high_q,
   output logic [TOTAL_W-1:0] total_q,
   output logic               hov_evt,
   output logic               roll_evt,
   output logic               full_seen,
   output logic               stop
);
   logic [PER_W-1:0] edges_q;
   logic             tick;
   logic             hsat, tsat, period_hit;

   generate
      if (DIV4) begin : g_slow
         logic [1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pre_q <= '0;
            else if (clear) pre_q <= '0;
            else if (run)   pre_q <= pre_q + 2'd1;
         end
         assign tick = run && (pre_q == 2'd3);
      end else begin : g_full
         assign tick = run;
      end
   endgenerate

   assign hsat       = &high_q;
   assign tsat       = &total_q;
   assign hov_evt    = run && lvl && hsat;
   assign roll_evt   = tick && tsat;
   assign period_hit = run && rise && (limit != '0) && ((edges_q + PER_W'(1)) == limit);
   assign full_seen  = (edges_q >= PER_W'(2)) || ((edges_q == PER_W'(1)) && rise);
   assign stop       = hov_evt || roll_evt || period_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         high_q  <= '0;
         total_q <= '0;
         edges_q <= '0;
      end else if (clear) begin
         high_q  <= '0;
         total_q <= '0;
         edges_q <= '0;
      end else if (run) begin
         if (lvl && !hsat)            high_q  <= high_q + HIGH_W'(1);
         if (tick && !tsat)           total_q <= total_q + TOTAL_W'(1);
         if (rise && !(&edges_q))     edges_q <= edges_q + PER_W'(1);
      end
   end
endmodule

// File: rtl/dm_divider.sv
module dm_divider #(
   parameter int NUM_W = 20,
   parameter int DEN_W = 16,
   parameter int Q_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [Q_W-1:0]   quo,
   output logic             fin
);
   localparam int CW  = (NUM_W > DEN_W) ? NUM_W : DEN_W;
   localparam int CNW = $clog2(Q_W + 1);

   logic [CW-1:0]    num_x, den_x;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W:0]   shl, den_e;
   logic [CNW-1:0]   cnt_q;
   logic             act_q;

   assign num_x = CW'(num);
   assign den_x = CW'(den);
   assign shl   = {rem_q, 1'b0};
   assign den_e = {1'b0, den};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo   <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
         fin   <= 1'b0;
      end else if (go) begin
         if (num_x >= den_x) begin
            quo   <= '1;
            act_q <= 1'b0;
            fin   <= 1'b1;
         end else begin
            rem_q <= DEN_W'(num_x);
            quo   <= '0;
            cnt_q <= CNW'(Q_W);
            act_q <= 1'b1;
            fin   <= 1'b0;
         end
      end else if (act_q) begin
         if (shl >= den_e) begin
            rem_q <= DEN_W'(shl - den_e);
            quo   <= {quo[Q_W-2:0], 1'b1};
         end else begin
            rem_q <= DEN_W'(shl);
            quo   <= {quo[Q_W-2:0], 1'b0};
         end
         cnt_q <= cnt_q - CNW'(1);
         if (cnt_q == CNW'(1)) begin
            act_q <= 1'b0;
            fin   <= 1'b1;
         end
      end else begin
         fin <= 1'b0;
      end
   end
endmodule

// File: rtl/duty_meter.sv
module duty_meter
   import dm_pkg::*;
#(
   parameter int  HIGH_W  = 20,
   parameter int  TOTAL_W = 16,
   parameter int  PER_W   = 8,
   parameter int  RATIO_W = 10,
   parameter bit  DIV4    = 1'b0,
   localparam int SH      = DIV4 ? 2 : 0,
   localparam int TE      = TOTAL_W + SH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               pulse_in,
   input  logic [PER_W-1:0]   period_limit,
   output logic               busy,
   output logic               done,
   output logic [HIGH_W-1:0]  high_count,
   output logic [TE-1:0]      total_count,
   output logic [RATIO_W-1:0] duty_ratio,
   output logic               hovf_flag,
   output logic               invalid_flag
);
   if (HIGH_W < 2)  begin : g_bad_high  $error("HIGH_W must be at least 2");  end
   if (TOTAL_W < 2) begin : g_bad_total $error("TOTAL_W must be at least 2"); end
   if (PER_W < 2)   begin : g_bad_per   $error("PER_W must be at least 2");   end
   if (RATIO_W < 2) begin : g_bad_ratio $error("RATIO_W must be at least 2"); end

   dm_state_e           state_q;
   logic                lvl, rise;
   logic                clear, run, div_go, div_fin;
   logic                hov_evt, roll_evt, full_seen, stop;
   logic [TOTAL_W-1:0]  total_raw;

   assign clear  = (state_q == DM_IDLE) && start;
   assign run    = (state_q == DM_RUN);
   assign div_go = (state_q == DM_LOAD);
   assign busy   = (state_q != DM_IDLE);

   dm_sync u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pulse_in),
      .lvl  (lvl),
      .rise (rise)
   );

   dm_counters #(
      .HIGH_W (HIGH_W),
      .TOTAL_W(TOTAL_W),
      .PER_W  (PER_W),
      .DIV4   (DIV4)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .run      (run),
      .lvl      (lvl),
      .rise     (rise),
      .limit    (period_limit),
      .high_q   (high_count),
      .total_q  (total_raw),
      .hov_evt  (hov_evt),
      .roll_evt (roll_evt),
      .full_seen(full_seen),
      .stop     (stop)
   );

   generate
      if (DIV4) begin : g_shift
         assign total_count = {total_raw, 2'b00};
      end else begin : g_plain
         assign total_count = total_raw;
      end
   endgenerate

   dm_divider #(
      .NUM_W(HIGH_W),
      .DEN_W(TE),
      .Q_W  (RATIO_W)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (div_go),
      .num  (high_count),
      .den  (total_count),
      .quo  (duty_ratio),
      .fin  (div_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= DM_IDLE;
         done         <= 1'b0;
         hovf_flag    <= 1'b0;
         invalid_flag <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            DM_IDLE: if (start) begin
               state_q      <= DM_RUN;
               hovf_flag    <= 1'b0;
               invalid_flag <= 1'b0;
            end
            DM_RUN: if (stop) begin
               state_q      <= DM_LOAD;
               hovf_flag    <= hov_evt;
               invalid_flag <= roll_evt && !full_seen;
            end
            DM_LOAD: state_q <= DM_DIV;
            DM_DIV: if (div_fin) begin
               state_q <= DM_IDLE;
               done    <= 1'b1;
            end
            default: state_q <= DM_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dm_checker.sv
module dm_checker #(
   parameter int HIGH_W = 20,
   parameter int TE     = 16,
   parameter int SH     = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [HIGH_W-1:0] high_count,
   input logic [TE-1:0]     total_count,
   input logic              hovf_flag,
   input logic              invalid_flag
);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R2
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && high_count == '0 && total_count == '0
                            && !hovf_flag && !invalid_flag));

   // R3
   total_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (total_count >= $past(total_count)));

   // R5
   hov_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hovf_flag |-> (&high_count));

   // R6
   roll_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_flag |-> (&total_count[TE-1:SH]));

   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && hovf_flag) |=> hovf_flag);
endmodule

bind duty_meter dm_checker #(
   .HIGH_W(HIGH_W),
   .TE    (TE),
   .SH    (SH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .high_count  (high_count),
   .total_count (total_count),
   .hovf_flag   (hovf_flag),
   .invalid_flag(invalid_flag)
);

// File: tb/duty_meter_test.sv
module dm_ref #(
   parameter int HW = 8,
   parameter int TW = 10,
   parameter bit D4 = 1'b0
) (
   input  logic clk,
   input  logic start,
   input  logic pulse,
   input  int   lim,
   output longint e_high,
   output longint e_total,
   output bit     e_hov,
   output bit     e_inv
);
   bit     s1 = 0, s2 = 0, pv = 0, running = 0;
   longint h = 0, t = 0;
   int     e = 0, pre = 0;

   always @(posedge clk) begin
      if (!running && start) begin
         h = 0; t = 0; e = 0; pre = 0;
         e_hov = 0; e_inv = 0;
         running = 1;
      end else if (running) begin
         bit rs, hs, tk, roll, ph;
         rs = s2 && !pv;
         hs = (h == (64'd1 << HW) - 1);
         if (s2) begin
            if (hs) e_hov = 1; else h++;
         end
         tk = D4 ? (pre == 3) : 1'b1;
         pre = (pre + 1) % 4;
         roll = 0;
         if (tk) begin
            if (t == (64'd1 << TW) - 1) roll = 1; else t++;
         end
         if (rs) e++;
         ph = rs && (lim != 0) && (e == lim);
         if ((s2 && hs) || roll || ph) begin
            running = 0;
            e_inv = roll && (e < 2);
         end
      end
      pv = s2; s2 = s1; s1 = pulse;
      e_high  = h;
      e_total = D4 ? t * 4 : t;
   end
endmodule

module duty_meter_test;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 10;

   logic clk = 0, rst_n = 0, start = 0, pulse_in = 0;
   logic [7:0] period_limit = 8'd0;
   int   lim = 0, pp = 4, hh = 2, ph = 0;
   int   errors = 0, checks = 0;

   logic busy_a, done_a, hov_a, inv_a;
   logic [7:0] high_a;
   logic [9:0] tot_a;
   logic [RW-1:0] rat_a;
   logic busy_b, done_b, hov_b, inv_b;
   logic [11:0] high_b;
   logic [11:0] tot_b;
   logic [RW-1:0] rat_b;

   longint eh_a, et_a, eh_b, et_b;
   bit ehov_a, einv_a, ehov_b, einv_b;

   always #(CLK_PERIOD/2) clk = ~clk;

   duty_meter #(.HIGH_W(8), .TOTAL_W(10), .PER_W(8), .RATIO_W(RW), .DIV4(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .pulse_in(pulse_in),
      .period_limit(period_limit), .busy(busy_a), .done(done_a),
      .high_count(high_a), .total_count(tot_a), .duty_ratio(rat_a),
      .hovf_flag(hov_a), .invalid_flag(inv_a));

   duty_meter #(.HIGH_W(12), .TOTAL_W(10), .PER_W(8), .RATIO_W(RW), .DIV4(1'b1)) uut_q4 (
      .clk(clk), .rst_n(rst_n), .start(start), .pulse_in(pulse_in),
      .period_limit(period_limit), .busy(busy_b), .done(done_b),
      .high_count(high_b), .total_count(tot_b), .duty_ratio(rat_b),
      .hovf_flag(hov_b), .invalid_flag(inv_b));

   dm_ref #(.HW(8),  .TW(10), .D4(1'b0)) ref_a (.clk(clk), .start(start), .pulse(pulse_in),
      .lim(lim), .e_high(eh_a), .e_total(et_a), .e_hov(ehov_a), .e_inv(einv_a));
   dm_ref #(.HW(12), .TW(10), .D4(1'b1)) ref_b (.clk(clk), .start(start), .pulse(pulse_in),
      .lim(lim), .e_high(eh_b), .e_total(et_b), .e_hov(ehov_b), .e_inv(einv_b));

   always @(negedge clk) begin
      pulse_in <= (ph < hh);
      ph <= (ph + 1 >= pp) ? 0 : ph + 1;
   end

   function automatic longint exp_ratio(longint h, longint t);
      if (h >= t) return (64'd1 << RW) - 1;
      return (h << RW) / t;
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_a();
      check(high_a == eh_a, "R1", "A high", high_a, eh_a);
      check(tot_a == et_a, "R3", "A total", tot_a, et_a);
      check(hov_a == ehov_a, "R5", "A hovf", hov_a, ehov_a);
      check(inv_a == einv_a, "R7", "A invalid", inv_a, einv_a);
      check(rat_a == exp_ratio(eh_a, et_a), "R8", "A ratio", rat_a, exp_ratio(eh_a, et_a));
      check(!busy_a, "R9", "A busy at done", busy_a, 0);
   endtask

   task automatic check_b();
      check(high_b == eh_b, "R1", "B high", high_b, eh_b);
      check(tot_b == et_b, "R3", "B shifted total", tot_b, et_b);
      check(tot_b[1:0] == 2'b00, "R3", "B low bits", tot_b[1:0], 0);
      check(hov_b == ehov_b, "R5", "B hovf", hov_b, ehov_b);
      check(inv_b == einv_b, "R7", "B invalid", inv_b, einv_b);
      check(rat_b == exp_ratio(eh_b, et_b), "R8", "B ratio", rat_b, exp_ratio(eh_b, et_b));
   endtask

   task automatic measure(int p, int h, int l, bit extra, string tag);
      bit ga = 0, gb = 0, la = 0, lb = 0;
      int cyc = 0;
      @(negedge clk);
      pp = p; hh = h; lim = l; period_limit = 8'(l);
      start = 1;
      @(negedge clk);
      start = 0;
      if (extra) begin
         @(negedge clk);
         start = 1;
         check(busy_a && busy_b, "R10", "busy before ignored start", busy_a, 1);
         @(negedge clk);
         start = 0;
      end
      while (!(ga && gb) && cyc < 30000) begin
         if (la) check(!done_a, "R9", "A done width", done_a, 0);
         if (lb) check(!done_b, "R9", "B done width", done_b, 0);
         la = done_a; lb = done_b;
         if (done_a && !ga) begin ga = 1; check_a(); end
         if (done_b && !gb) begin gb = 1; check_b(); end
         @(negedge clk);
         cyc++;
      end
      if (!(ga && gb)) check(0, "R9", {"watchdog ", tag}, cyc, 0);
      if (la) check(!done_a, "R9", "A done width", done_a, 0);
      if (lb) check(!done_b, "R9", "B done width", done_b, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      check(!busy_a && !done_a && !busy_b && !done_b, "R11", "busy/done", busy_a, 0);
      check(high_a == 0 && tot_a == 0 && rat_a == 0, "R11", "A outputs", high_a, 0);
      check(high_b == 0 && tot_b == 0 && rat_b == 0, "R11", "B outputs", high_b, 0);
      check(!hov_a && !inv_a && !hov_b && !inv_b, "R11", "flags", hov_a, 0);

      // R4 edge limit of 100
      measure(4, 1, 100, 0, "R4 limit100");
      check(eh_a == 100 || eh_a == 99 || eh_a == 101, "R4", "A high near 100", eh_a, 100);
      // R6 R7 constant low: rollover with no edges
      measure(8, 0, 5, 0, "R6 low");
      check(inv_a && tot_a == 10'h3FF, "R6", "A rolled total", tot_a, 1023);
      check(inv_b && tot_b == 12'hFFC, "R7", "B rolled total", tot_b, 4092);
      // R5 constant high: A overflows
      measure(8, 8, 5, 0, "R5 high");
      check(hov_a && high_a == 8'hFF, "R5", "A saturated", high_a, 255);
      // R5 long high phases with edges
      measure(600, 500, 3, 1, "R5 long");
      // R10 start while busy after overflow set
      measure(300, 290, 4, 1, "R10 busy start");
      // R2 random runs with restart clearing
      for (int i = 0; i < 24; i++) begin
         int p, h, l;
         p = $urandom_range(24, 4);
         h = $urandom_range(p, 0);
         l = $urandom_range(12, 2);
         measure(p, h, l, (i % 3) == 0, "R2 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule